// File: doc/BRIEF.md
# Chained I2C Slave Address Decoder

This block is the receiving front end of one node on a daisy-chained battery-monitor bus that uses I2C signalling. It takes the raw clock and data lines, removes short spikes from both, and follows the bus framing. It finds START, repeated START and STOP conditions, keeps a bus-busy flag, and collects the first byte after every START.

That first byte is sorted into one of several command classes. The first class is a broadcast address that any node accepts, for reads or writes. The second is a greeting command that every node acknowledges. The third is a device-write command whose five-bit node address is carried with its bits reversed and must match the locally programmed address. When the byte is recognised, the block pulls the data line low for the ninth clock pulse. In every case it then reports the class and the raw byte for one cycle to the command logic behind it. After an unrecognised byte it stays silent until the next START or STOP.

Top module: `chain_addr_slave`

## Requirements
- R1: A falling filtered SDA while filtered SCL is high is a START and sets `busBusy` to 1. A rising filtered SDA while filtered SCL is high is a STOP and clears `busBusy` to 0.
- R2: A repeated START, which is a START while `busBusy` is 1, keeps `busBusy` at 1 and restarts address collection from the first bit.
- R3: The first 8 SCL rising edges after a START sample the address byte, most significant bit first. Bit 0 is the read/write flag, with 1 meaning read.
- R4: A byte whose bits 7..1 are 0100000 is a broadcast. It is reported as class 1 (broadcast read) for byte 0x41 and as class 2 (broadcast write) for byte 0x40, and it is acknowledged.
- R5: A byte with bits 7..6 = 11 and bit 0 = 0 is the greeting command, class 3. It is acknowledged whatever bits 5..1 hold. With bit 0 = 1 the byte is class 0.
- R6: A byte with bits 7..6 = 10 and bit 0 = 0 is a device write. Bit 5 holds address bit 0, bit 4 holds address bit 1, and so on up to bit 1, which holds address bit 4. The byte is class 4 and is acknowledged only when that field equals `localAddr`. Otherwise it is class 0 and is not acknowledged.
- R7: For an acknowledged byte, `sdaDriveLow` is 1 from just after the SCL fall that ends bit 8 until just after the SCL fall that ends the ninth pulse. For a byte that is not acknowledged, `sdaDriveLow` stays 0.
- R8: A pulse on SCL or SDA shorter than `FILT_LEN` clock cycles has no effect on framing, on decoding or on `busBusy`.
- R9: After a class 0 byte, the block neither drives SDA nor reports any further byte until the next START or STOP.
- R10: A few cycles after the SCL fall that ends the ninth pulse, `classValid` is high for exactly one cycle. In that cycle `classCode` holds the class (0 none, 1 broadcast read, 2 broadcast write, 3 greeting, 4 device write) and `rxByte` holds the received byte.
- R11: After reset, `busBusy`, `sdaDriveLow` and `classValid` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rstN | input | 1 | Asynchronous active-low reset |
| sclIn | input | 1 | Raw bus clock level |
| sdaIn | input | 1 | Raw bus data level |
| localAddr | input | 5 | Programmed node address |
| sdaDriveLow | output | 1 | Open-drain enable: 1 pulls SDA low |
| busBusy | output | 1 | Bus held between START and STOP |
| classValid | output | 1 | One-cycle strobe for a decoded address byte |
| classCode | output | 3 | Decoded class of the address byte |
| rxByte | output | 8 | Received address byte |

## Verification
The decoder is driven with one byte from each class: 0x40, 0x41, a greeting with an arbitrary address field, a device write whose reversed field matches the local address, and one whose field does not match. The last of these separates a correct bit-reversal and compare from a plain field compare. A greeting byte with the read flag set, and a second local address value, check that the read/write flag and `localAddr` both take part in the decision. A repeated START between two bytes checks that collection restarts. A data byte sent after a NACK shows whether the block really stays silent. Single-cycle spikes on idle SDA and on SCL in the middle of a byte tell a working filter apart from one that passes glitches, which would show up as a false START or a shifted byte.

// File: rtl/addr_pkg.sv
package addr_pkg;
  localparam int BYTE_W = 8;
  localparam int ADDR_W = 5;
  localparam int CNT_W  = $clog2(BYTE_W + 1);

  localparam logic [BYTE_W-2:0] BCAST_TAG = 7'b0100000;
  localparam logic [1:0]        HELLO_TAG = 2'b11;
  localparam logic [1:0]        WRDEV_TAG = 2'b10;

  typedef enum logic [2:0] {
    CLS_NONE   = 3'd0,
    CLS_BREAD  = 3'd1,
    CLS_BWRITE = 3'd2,
    CLS_HELLO  = 3'd3,
    CLS_WRDEV  = 3'd4
  } addrClass_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ACK,
    ST_NACK,
    ST_SKIP
  } ctrlState_e;

  typedef struct packed {
    logic start;
    logic stop;
    logic sclRise;
    logic sclFall;
  } busEvt_t;

  typedef struct packed {
    logic clrShift;
    logic shiftBit;
    logic capture;
  } ctrlStrobe_t;
endpackage

// File: rtl/line_filter.sv
module line_filter #(
  parameter int   FILT_LEN  = 3,
  parameter logic RESET_VAL = 1'b1
) (
  input  logic clk,
  input  logic rstN,
  input  logic rawIn,
  output logic filtOut
);
  localparam int CW = $clog2(FILT_LEN + 1);
  localparam logic [CW-1:0] LIMIT = CW'(FILT_LEN - 1);

  logic syncA, syncB;
  logic [CW-1:0] runCnt;

  // two-flop synchroniser
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncA <= RESET_VAL;
      syncB <= RESET_VAL;
    end else begin
      syncA <= rawIn;
      syncB <= syncA;
    end
  end

  // level changes only after FILT_LEN consecutive differing samples
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      runCnt  <= '0;
      filtOut <= RESET_VAL;
    end else if (syncB == filtOut) begin
      runCnt <= '0;
    end else if (runCnt == LIMIT) begin
      runCnt  <= '0;
      filtOut <= syncB;
    end else begin
      runCnt <= runCnt + 1'b1;
    end
  end
endmodule

// File: rtl/addr_datapath.sv
module addr_datapath
  import addr_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclFilt,
  input  logic              sdaFilt,
  input  logic [ADDR_W-1:0] localAddr,
  input  ctrlStrobe_t       strobe,
  output busEvt_t           evt,
  output logic              byteDone,
  output logic              ackWanted,
  output logic [2:0]        classCode,
  output logic [BYTE_W-1:0] rxByte
);
  logic sclPrev, sdaPrev;
  logic [BYTE_W-1:0] shiftReg;
  logic [CNT_W-1:0]  bitCnt;
  logic [ADDR_W-1:0] addrField;
  addrClass_e        cls;

  // previous filtered levels, idle bus is high
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclPrev <= 1'b1;
      sdaPrev <= 1'b1;
    end else begin
      sclPrev <= sclFilt;
      sdaPrev <= sdaFilt;
    end
  end

  always_comb begin
    evt.start   = sclPrev && sclFilt && sdaPrev && !sdaFilt;
    evt.stop    = sclPrev && sclFilt && !sdaPrev && sdaFilt;
    evt.sclRise = !sclPrev && sclFilt;
    evt.sclFall = sclPrev && !sclFilt;
  end

  // bit collection, MSB first
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg <= '0;
      bitCnt   <= '0;
    end else if (strobe.clrShift) begin
      shiftReg <= '0;
      bitCnt   <= '0;
    end else if (strobe.shiftBit) begin
      shiftReg <= {shiftReg[BYTE_W-2:0], sdaFilt};
      bitCnt   <= bitCnt + 1'b1;
    end
  end

  assign byteDone = (bitCnt == CNT_W'(BYTE_W));

  // node address travels reversed: lowest address bit sits highest
  for (genvar gi = 0; gi < ADDR_W; gi++) begin : g_rev
    assign addrField[gi] = shiftReg[ADDR_W - gi];
  end

  always_comb begin
    cls = CLS_NONE;
    if (shiftReg[BYTE_W-1:1] == BCAST_TAG) begin
      cls = shiftReg[0] ? CLS_BREAD : CLS_BWRITE;
    end else if (!shiftReg[0]) begin
      if (shiftReg[BYTE_W-1 -: 2] == HELLO_TAG) begin
        cls = CLS_HELLO;
      end else if (shiftReg[BYTE_W-1 -: 2] == WRDEV_TAG && addrField == localAddr) begin
        cls = CLS_WRDEV;
      end
    end
  end

  assign ackWanted = (cls != CLS_NONE);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      classCode <= CLS_NONE;
      rxByte    <= '0;
    end else if (strobe.capture) begin
      classCode <= cls;
      rxByte    <= shiftReg;
    end
  end
endmodule

// File: rtl/addr_control.sv
module addr_control
  import addr_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  busEvt_t     evt,
  input  logic        byteDone,
  input  logic        ackWanted,
  output ctrlStrobe_t strobe,
  output logic        sdaDriveLow,
  output logic        busBusy,
  output logic        classValid
);
  ctrlState_e state, stateNext;

  always_comb begin
    stateNext       = state;
    strobe          = '0;
    if (evt.start) begin
      stateNext       = ST_ADDR;
      strobe.clrShift = 1'b1;
    end else if (evt.stop) begin
      stateNext = ST_IDLE;
    end else begin
      unique case (state)
        ST_ADDR: begin
          if (evt.sclRise && !byteDone) begin
            strobe.shiftBit = 1'b1;
          end else if (evt.sclFall && byteDone) begin
            stateNext = ackWanted ? ST_ACK : ST_NACK;
          end
        end
        ST_ACK, ST_NACK: begin
          if (evt.sclFall) begin
            strobe.capture = 1'b1;
            stateNext      = ST_SKIP;
          end
        end
        default: stateNext = state;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state       <= ST_IDLE;
      busBusy     <= 1'b0;
      sdaDriveLow <= 1'b0;
      classValid  <= 1'b0;
    end else begin
      state       <= stateNext;
      sdaDriveLow <= (stateNext == ST_ACK);
      classValid  <= strobe.capture;
      if (evt.start) begin
        busBusy <= 1'b1;
      end else if (evt.stop) begin
        busBusy <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/chain_addr_slave.sv
module chain_addr_slave
  import addr_pkg::*;
#(
  parameter int FILT_LEN = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclIn,
  input  logic              sdaIn,
  input  logic [ADDR_W-1:0] localAddr,
  output logic              sdaDriveLow,
  output logic              busBusy,
  output logic              classValid,
  output logic [2:0]        classCode,
  output logic [BYTE_W-1:0] rxByte
);
  localparam int NLINES = 2;

  logic [NLINES-1:0] rawLines, filtLines;
  logic sclFilt, sdaFilt;
  busEvt_t     evt;
  ctrlStrobe_t strobe;
  logic byteDone, ackWanted;

  assign rawLines = {sdaIn, sclIn};

  for (genvar li = 0; li < NLINES; li++) begin : g_filt
    line_filter #(.FILT_LEN(FILT_LEN), .RESET_VAL(1'b1)) u_filt (
      .clk(clk), .rstN(rstN), .rawIn(rawLines[li]), .filtOut(filtLines[li])
    );
  end

  assign sclFilt = filtLines[0];
  assign sdaFilt = filtLines[1];

  addr_datapath u_dp (
    .clk(clk), .rstN(rstN), .sclFilt(sclFilt), .sdaFilt(sdaFilt),
    .localAddr(localAddr), .strobe(strobe), .evt(evt), .byteDone(byteDone),
    .ackWanted(ackWanted), .classCode(classCode), .rxByte(rxByte)
  );

  addr_control u_ctl (
    .clk(clk), .rstN(rstN), .evt(evt), .byteDone(byteDone), .ackWanted(ackWanted),
    .strobe(strobe), .sdaDriveLow(sdaDriveLow), .busBusy(busBusy),
    .classValid(classValid)
  );
endmodule

// File: rtl/chain_addr_slave_chk.sv
module chain_addr_slave_chk (
  input logic       clk,
  input logic       rstN,
  input logic       sclFilt,
  input logic       sdaDriveLow,
  input logic       busBusy,
  input logic       classValid,
  input logic [2:0] classCode,
  input logic [7:0] rxByte,
  input logic [4:0] localAddr
);
  // R10
  valid_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    classValid |=> !classValid);
  // R7
  drive_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    sdaDriveLow |-> busBusy);
  // R7
  drive_sclow_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sdaDriveLow) |-> !sclFilt);
  // R4
  bcast_byte_chk: assert property (@(posedge clk) disable iff (!rstN)
    (classValid && (classCode == 3'd1 || classCode == 3'd2)) |->
      (rxByte == {7'b0100000, classCode == 3'd1}));
  // R5
  hello_byte_chk: assert property (@(posedge clk) disable iff (!rstN)
    (classValid && classCode == 3'd3) |-> (rxByte[7:6] == 2'b11 && !rxByte[0]));
  // R6
  wrdev_addr_chk: assert property (@(posedge clk) disable iff (!rstN)
    (classValid && classCode == 3'd4) |->
      ({rxByte[1], rxByte[2], rxByte[3], rxByte[4], rxByte[5]} == localAddr
       && rxByte[7:6] == 2'b10 && !rxByte[0]));
endmodule

bind chain_addr_slave chain_addr_slave_chk u_chk (
  .clk(clk), .rstN(rstN), .sclFilt(sclFilt), .sdaDriveLow(sdaDriveLow),
  .busBusy(busBusy), .classValid(classValid), .classCode(classCode),
  .rxByte(rxByte), .localAddr(localAddr)
);

// File: tb/tb_chain_addr_slave.sv
module tb_chain_addr_slave;
  localparam int HP = 16;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sclM = 1'b1;
  logic sdaM = 1'b1;
  logic [4:0] localAddr = 5'b10110;
  logic sdaIn;
  logic sdaDriveLow, busBusy, classValid;
  logic [2:0] classCode;
  logic [7:0] rxByte;

  int checks = 0;
  int errors = 0;
  logic [10:0] expQ[$];

  always #5 clk = ~clk;

  assign sdaIn = sdaM & ~sdaDriveLow;

  chain_addr_slave dut (
    .clk(clk), .rstN(rstN), .sclIn(sclM), .sdaIn(sdaIn), .localAddr(localAddr),
    .sdaDriveLow(sdaDriveLow), .busBusy(busBusy), .classValid(classValid),
    .classCode(classCode), .rxByte(rxByte)
  );

  function automatic logic [2:0] expCls(input logic [7:0] b, input logic [4:0] la);
    logic [4:0] fld;
    for (int i = 0; i < 5; i++) fld[i] = b[5 - i];
    if (b == 8'h41) return 3'd1;
    if (b == 8'h40) return 3'd2;
    if (b[0]) return 3'd0;
    case (b[7:6])
      2'b11:   return 3'd3;
      2'b10:   return (fld == la) ? 3'd4 : 3'd0;
      default: return 3'd0;
    endcase
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic waitCyc(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic startCond();
    sdaM = 1'b0; waitCyc(HP);
    sclM = 1'b0; waitCyc(HP);
  endtask

  task automatic restartCond();
    sdaM = 1'b1; waitCyc(HP);
    sclM = 1'b1; waitCyc(HP);
    check("R2 busy held before repeated start", busBusy, 1);
    sdaM = 1'b0; waitCyc(HP);
    sclM = 1'b0; waitCyc(HP);
    check("R2 busy held after repeated start", busBusy, 1);
  endtask

  task automatic stopCond();
    sdaM = 1'b0; waitCyc(HP);
    sclM = 1'b1; waitCyc(HP);
    sdaM = 1'b1; waitCyc(HP);
    check("R1 busy cleared by stop", busBusy, 0);
  endtask

  // report: byte is an address byte expected to be decoded
  // glitchAt: bit index before which a one-cycle SCL spike is injected, -1 none
  task automatic sendByte(input logic [7:0] b, input bit report, input int glitchAt);
    logic [2:0] c;
    bit ackExp;
    c = expCls(b, localAddr);
    ackExp = report && (c != 3'd0);
    for (int i = 7; i >= 0; i--) begin
      sdaM = b[i];
      waitCyc(HP / 2);
      if (i == glitchAt) begin
        sclM = 1'b1; waitCyc(1); sclM = 1'b0;
      end
      waitCyc(HP / 2);
      sclM = 1'b1; waitCyc(HP);
      sclM = 1'b0; waitCyc(2);
    end
    sdaM = 1'b1;
    if (report) expQ.push_back({c, b});
    waitCyc(HP);
    check(report ? "R7 drive during ack low phase" : "R9 no drive after nack",
          sdaDriveLow, ackExp);
    sclM = 1'b1; waitCyc(HP / 2);
    check(report ? "R7 sda level in ninth pulse" : "R9 sda released when ignoring",
          sdaIn, !ackExp);
    waitCyc(HP / 2);
    sclM = 1'b0; waitCyc(12);
    check("R7 sda released after ninth pulse", sdaDriveLow, 0);
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rstN && classValid) begin
      if (expQ.size() == 0) begin
        checks++; errors++;
        $display("FAIL R9 unexpected report actual=%0h expected=none", {classCode, rxByte});
      end else begin
        logic [10:0] e;
        e = expQ.pop_front();
        check("R10 class code", classCode, e[10:8]);
        check("R3 received byte", rxByte, e[7:0]);
      end
    end
  end

  initial begin
    fork
      begin
        waitCyc(150000);
        checks++; errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
      end
    join_none

    waitCyc(3);
    rstN = 1'b1;
    waitCyc(2);
    check("R11 reset busy", busBusy, 0);
    check("R11 reset drive", sdaDriveLow, 0);
    check("R11 reset valid", classValid, 0);

    // R8: one-cycle SDA spike on idle bus is no START
    sdaM = 1'b0; waitCyc(1); sdaM = 1'b1;
    waitCyc(HP);
    check("R8 sda spike ignored", busBusy, 0);

    // R1, R4: broadcast write
    startCond();
    check("R1 busy after start", busBusy, 1);
    sendByte(8'h40, 1, -1);
    stopCond();

    // R4 broadcast read, then R2/R6 repeated start into matching device write
    startCond();
    sendByte(8'h41, 1, -1);
    restartCond();
    sendByte(8'h9A, 1, -1);
    stopCond();

    // R5 greeting with an arbitrary address field
    startCond();
    sendByte(8'hD6, 1, -1);
    stopCond();

    // R6 mismatching device write, then R9 ignored following byte
    startCond();
    sendByte(8'h98, 1, -1);
    sendByte(8'h40, 0, -1);
    stopCond();

    // R5 greeting with read flag set is class none
    startCond();
    sendByte(8'hC1, 1, -1);
    stopCond();

    // R8 SCL spike inside a byte does not add a bit
    startCond();
    sendByte(8'h40, 1, 3);
    stopCond();

    // R6 with another local address
    localAddr = 5'b00000;
    waitCyc(4);
    startCond();
    sendByte(8'h80, 1, -1);
    stopCond();

    waitCyc(20);
    check("R10 every decoded byte reported", expQ.size(), 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule